// File: doc/BRIEF.md
# Mailbox Doorbell Controller

This block passes 32-bit messages between two register ports that share one clock. One port is the host side and the other is the local side. Each direction has eight mailbox words. The sending side writes a mailbox and can read it back. The receiving side sees the same word at its own address, where it is read-only.

Every write to a mailbox rings a doorbell for the receiver. A sticky status bit is set in the receiver's status register. The receiver clears that bit by writing a one to it. Each side has an enable register, and its level interrupt output is high while any enabled status bit is set.

Host map: status 0x0040, enable 0x0050, outbound mailboxes 0x0800–0x081F, inbound mailboxes 0x0900–0x091F.
Local map: status 0x3060, enable 0x3070, outbound mailboxes 0x3A00–0x3A1F, inbound mailboxes 0x3B00–0x3B1F.

Top module: `mbox_doorbell`

## Requirements
- R1: A host write to 0x0800+4N updates host-to-local mailbox N in the bytes whose byte-enable bit is set. The local side reads the word at 0x3B00+4N, and the host reads it back at 0x0800+4N.
- R2: A local write to 0x3A00+4N updates local-to-host mailbox N in the enabled bytes. The host reads the word at 0x0900+4N, and the local side reads it back at 0x3A00+4N.
- R3: Any write to a mailbox N sets bit 16+N of the receiving side's status register. The host status register is at 0x0040 and the local status register is at 0x3060. The bit is set even when no byte enable is active.
- R4: Status bits are write-one-to-clear. A clear takes effect only when byte enable bit 2 is set. A zero written to a bit leaves it unchanged.
- R5: If a mailbox write sets a status bit in the same cycle that the receiver clears that bit, the bit ends up set.
- R6: In the status and enable registers only bits [23:16] exist. All other bits read zero. An enable write (host 0x0050, local 0x3070) changes bits [23:16] only when byte enable bit 2 is set.
- R7: Each side's interrupt output is a level signal. It is high exactly when some status bit and the matching enable bit are both set.
- R8: Writes to read-only mailbox windows and to unmapped offsets have no effect. Reads of unmapped offsets return zero.
- R9: Read data appears on the clock after the read strobe. The read data output is zero in a cycle that follows no read.
- R10: Reset clears all mailboxes, status bits, enable bits, read data and interrupt outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rst_n | input | 1 | Active-low reset |
| host_addr | input | 32 | Host byte address |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_be | input | 4 | Host byte enables |
| host_rdata | output | 32 | Host read data, one cycle later |
| host_irq | output | 1 | Host level interrupt |
| loc_addr | input | 32 | Local byte address |
| loc_rd | input | 1 | Local read strobe |
| loc_wr | input | 1 | Local write strobe |
| loc_wdata | input | 32 | Local write data |
| loc_be | input | 4 | Local byte enables |
| loc_rdata | output | 32 | Local read data, one cycle later |
| loc_irq | output | 1 | Local level interrupt |

## Verification
The hardest case to reach is the collision where a mailbox write on one port and a clear of the same doorbell bit on the other port land on one clock edge. The bench drives both ports on the same falling edge to force this collision. It then reads the status back to show that the set was kept.

A second hard case is an enable write with byte lane 2 masked off. The bench checks this one through both the enable read-back and the interrupt level.

// File: rtl/mbox_doorbell.sv
module mbox_doorbell #(
  parameter int unsigned NBOX    = 8,
  parameter int unsigned DW      = 32,
  parameter int unsigned AW      = 32,
  parameter int unsigned STS_LSB = 16,
  parameter logic [AW-1:0] H_STS = 32'h0000_0040,
  parameter logic [AW-1:0] H_EN  = 32'h0000_0050,
  parameter logic [AW-1:0] H_TX  = 32'h0000_0800,
  parameter logic [AW-1:0] H_RX  = 32'h0000_0900,
  parameter logic [AW-1:0] L_STS = 32'h0000_3060,
  parameter logic [AW-1:0] L_EN  = 32'h0000_3070,
  parameter logic [AW-1:0] L_TX  = 32'h0000_3A00,
  parameter logic [AW-1:0] L_RX  = 32'h0000_3B00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] host_addr,
  input  logic          host_rd,
  input  logic          host_wr,
  input  logic [DW-1:0] host_wdata,
  input  logic [DW/8-1:0] host_be,
  output logic [DW-1:0] host_rdata,
  output logic          host_irq,
  input  logic [AW-1:0] loc_addr,
  input  logic          loc_rd,
  input  logic          loc_wr,
  input  logic [DW-1:0] loc_wdata,
  input  logic [DW/8-1:0] loc_be,
  output logic [DW-1:0] loc_rdata,
  output logic          loc_irq
);
  localparam int unsigned IW  = (NBOX > 1) ? $clog2(NBOX) : 1;
  localparam int unsigned WIN = NBOX * (DW / 8);
  localparam int unsigned NB  = DW / 8;

  function automatic logic word_hit(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return a[AW-1:2] == b[AW-1:2];
  endfunction

  function automatic logic win_hit(input logic [AW-1:0] a, input logic [AW-1:0] b);
    logic [AW-1:0] d;
    d = a - b;
    return d < AW'(WIN);
  endfunction

  function automatic logic [DW-1:0] lane_mask(input logic [NB-1:0] be);
    logic [DW-1:0] m;
    for (int i = 0; i < NB; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction

  logic [DW-1:0]   h2l [NBOX];
  logic [DW-1:0]   l2h [NBOX];
  logic [NBOX-1:0] h_sts, h_en, l_sts, l_en;

  logic [IW-1:0] h_idx, l_idx;
  assign h_idx = host_addr[IW+1:2];
  assign l_idx = loc_addr[IW+1:2];

  logic [DW-1:0] h_m, l_m;
  assign h_m = lane_mask(host_be);
  assign l_m = lane_mask(loc_be);

  logic h_tx_w, l_tx_w, h_sts_w, l_sts_w, h_en_w, l_en_w;
  assign h_tx_w  = host_wr && win_hit(host_addr, H_TX);
  assign l_tx_w  = loc_wr  && win_hit(loc_addr,  L_TX);
  assign h_sts_w = host_wr && word_hit(host_addr, H_STS);
  assign l_sts_w = loc_wr  && word_hit(loc_addr,  L_STS);
  assign h_en_w  = host_wr && word_hit(host_addr, H_EN);
  assign l_en_w  = loc_wr  && word_hit(loc_addr,  L_EN);

  logic [NBOX-1:0] h_set, l_set, h_clr, l_clr;
  assign h_set = l_tx_w ? NBOX'(1) << l_idx : '0;
  assign l_set = h_tx_w ? NBOX'(1) << h_idx : '0;
  assign h_clr = h_sts_w ? (host_wdata[STS_LSB +: NBOX] & h_m[STS_LSB +: NBOX]) : '0;
  assign l_clr = l_sts_w ? (loc_wdata[STS_LSB +: NBOX]  & l_m[STS_LSB +: NBOX])  : '0;

  for (genvar i = 0; i < NBOX; i++) begin : g_box
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        h2l[i] <= '0;
        l2h[i] <= '0;
      end else begin
        if (h_tx_w && h_idx == IW'(i)) h2l[i] <= (h2l[i] & ~h_m) | (host_wdata & h_m);
        if (l_tx_w && l_idx == IW'(i)) l2h[i] <= (l2h[i] & ~l_m) | (loc_wdata & l_m);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_sts <= '0;
      l_sts <= '0;
      h_en  <= '0;
      l_en  <= '0;
    end else begin
      h_sts <= (h_sts & ~h_clr) | h_set;
      l_sts <= (l_sts & ~l_clr) | l_set;
      if (h_en_w)
        h_en <= (h_en & ~h_m[STS_LSB +: NBOX]) | (host_wdata[STS_LSB +: NBOX] & h_m[STS_LSB +: NBOX]);
      if (l_en_w)
        l_en <= (l_en & ~l_m[STS_LSB +: NBOX]) | (loc_wdata[STS_LSB +: NBOX] & l_m[STS_LSB +: NBOX]);
    end
  end

  logic [DW-1:0] h_rd_d, l_rd_d;
  always_comb begin
    h_rd_d = '0;
    if (word_hit(host_addr, H_STS))     h_rd_d[STS_LSB +: NBOX] = h_sts;
    else if (word_hit(host_addr, H_EN)) h_rd_d[STS_LSB +: NBOX] = h_en;
    else if (win_hit(host_addr, H_TX))  h_rd_d = h2l[h_idx];
    else if (win_hit(host_addr, H_RX))  h_rd_d = l2h[h_idx];
  end

  always_comb begin
    l_rd_d = '0;
    if (word_hit(loc_addr, L_STS))     l_rd_d[STS_LSB +: NBOX] = l_sts;
    else if (word_hit(loc_addr, L_EN)) l_rd_d[STS_LSB +: NBOX] = l_en;
    else if (win_hit(loc_addr, L_TX))  l_rd_d = l2h[l_idx];
    else if (win_hit(loc_addr, L_RX))  l_rd_d = h2l[l_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata <= '0;
      loc_rdata  <= '0;
    end else begin
      host_rdata <= host_rd ? h_rd_d : '0;
      loc_rdata  <= loc_rd  ? l_rd_d : '0;
    end
  end

  assign host_irq = |(h_sts & h_en);
  assign loc_irq  = |(l_sts & l_en);

  // R3
  h2l_doorbell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    h_tx_w |=> l_sts[$past(h_idx)]);
  // R3
  l2h_doorbell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_tx_w |=> h_sts[$past(l_idx)]);
  // R4
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l_sts_w |=> (l_sts & $past(l_clr & ~l_set)) == '0);
  // R4
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !h_sts_w |=> (h_sts & $past(h_sts)) == $past(h_sts));
  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (l_en == '0) |-> !loc_irq);
  // R9
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> host_rdata == '0);
  // R8
  box_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !l_tx_w |=> $stable(l2h[0]));
endmodule

// File: tb/tb_mbox_doorbell.sv
`timescale 1ns/1ps
module tb_mbox_doorbell;
  logic clk = 0, rst_n = 0;
  logic [31:0] host_addr = 0, host_wdata = 0, loc_addr = 0, loc_wdata = 0;
  logic host_rd = 0, host_wr = 0, loc_rd = 0, loc_wr = 0;
  logic [3:0] host_be = 0, loc_be = 0;
  logic [31:0] host_rdata, loc_rdata;
  logic host_irq, loc_irq;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  mbox_doorbell dut (
    .clk(clk), .rst_n(rst_n),
    .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_be(host_be), .host_rdata(host_rdata), .host_irq(host_irq),
    .loc_addr(loc_addr), .loc_rd(loc_rd), .loc_wr(loc_wr),
    .loc_wdata(loc_wdata), .loc_be(loc_be), .loc_rdata(loc_rdata), .loc_irq(loc_irq));

  // {req[3:0], side(1=local), wr, rd, addr[15:0], be[3:0], data[31:0], exp[31:0]}
  localparam int NV = 24;
  localparam logic [90:0] VEC [NV] = '{
    {4'd1, 1'b0,1'b1,1'b0, 16'h0800, 4'hF, 32'h1111_1111, 32'h0},           // R1
    {4'd1, 1'b1,1'b0,1'b1, 16'h3B00, 4'h0, 32'h0,         32'h1111_1111},   // R1
    {4'd3, 1'b1,1'b0,1'b1, 16'h3060, 4'h0, 32'h0,         32'h0001_0000},   // R3
    {4'd1, 1'b0,1'b1,1'b0, 16'h081C, 4'h3, 32'hAABB_CCDD, 32'h0},           // R1
    {4'd1, 1'b1,1'b0,1'b1, 16'h3B1C, 4'h0, 32'h0,         32'h0000_CCDD},   // R1
    {4'd3, 1'b1,1'b0,1'b1, 16'h3060, 4'h0, 32'h0,         32'h0081_0000},   // R3
    {4'd4, 1'b1,1'b1,1'b0, 16'h3060, 4'hF, 32'h0001_0000, 32'h0},           // R4
    {4'd4, 1'b1,1'b0,1'b1, 16'h3060, 4'h0, 32'h0,         32'h0080_0000},   // R4
    {4'd8, 1'b1,1'b1,1'b0, 16'h3B00, 4'hF, 32'h0,         32'h0},           // R8
    {4'd8, 1'b1,1'b0,1'b1, 16'h3B00, 4'h0, 32'h0,         32'h1111_1111},   // R8
    {4'd2, 1'b1,1'b1,1'b0, 16'h3A08, 4'hF, 32'h1234_5678, 32'h0},           // R2
    {4'd2, 1'b0,1'b0,1'b1, 16'h0908, 4'h0, 32'h0,         32'h1234_5678},   // R2
    {4'd3, 1'b0,1'b0,1'b1, 16'h0040, 4'h0, 32'h0,         32'h0004_0000},   // R3
    {4'd4, 1'b0,1'b1,1'b0, 16'h0040, 4'hF, 32'h0,         32'h0},           // R4
    {4'd4, 1'b0,1'b0,1'b1, 16'h0040, 4'h0, 32'h0,         32'h0004_0000},   // R4
    {4'd8, 1'b0,1'b0,1'b1, 16'h0124, 4'h0, 32'h0,         32'h0},           // R8
    {4'd6, 1'b0,1'b1,1'b0, 16'h0050, 4'hF, 32'hFFFF_FFFF, 32'h0},           // R6
    {4'd6, 1'b0,1'b0,1'b1, 16'h0050, 4'h0, 32'h0,         32'h00FF_0000},   // R6
    {4'd2, 1'b1,1'b0,1'b1, 16'h3A08, 4'h0, 32'h0,         32'h1234_5678},   // R2
    {4'd8, 1'b0,1'b1,1'b0, 16'h0908, 4'hF, 32'h0,         32'h0},           // R8
    {4'd8, 1'b0,1'b0,1'b1, 16'h0908, 4'h0, 32'h0,         32'h1234_5678},   // R8
    {4'd2, 1'b1,1'b1,1'b0, 16'h3A08, 4'h4, 32'h0099_0000, 32'h0},           // R2
    {4'd2, 1'b0,1'b0,1'b1, 16'h0908, 4'h0, 32'h0,         32'h1299_5678},   // R2
    {4'd9, 1'b0,1'b0,1'b0, 16'h0908, 4'h0, 32'h0,         32'h0}            // R9 idle
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic op(input logic side, input logic wr, input logic rd, input logic [15:0] a,
                    input logic [3:0] be, input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    if (side) begin
      loc_addr = {16'h0, a}; loc_wr = wr; loc_rd = rd; loc_be = be; loc_wdata = d;
    end else begin
      host_addr = {16'h0, a}; host_wr = wr; host_rd = rd; host_be = be; host_wdata = d;
    end
    @(negedge clk);
    host_wr = 0; host_rd = 0; loc_wr = 0; loc_rd = 0;
    q = side ? loc_rdata : host_rdata;
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] q;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", {host_rdata[30:0], host_irq}, 32'h0);
    chk("R10", {loc_rdata[30:0], loc_irq}, 32'h0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      op(VEC[i][86], VEC[i][85], VEC[i][84], VEC[i][83:68], VEC[i][67:64], VEC[i][63:32], q);
      if (VEC[i][84] || (!VEC[i][85] && !VEC[i][84]))
        chk($sformatf("R%0d vec%0d", VEC[i][90:87], i), q, VEC[i][31:0]);
    end

    // R7 host enabled with bit 18 set, local not enabled with bit 23 set
    chk("R7 host_irq", {31'h0, host_irq}, 32'h1);
    chk("R7 loc_irq", {31'h0, loc_irq}, 32'h0);
    // R6 enable write with lane 2 masked is ignored
    op(1, 1, 0, 16'h3070, 4'b1011, 32'hFFFF_FFFF, q);
    op(1, 0, 1, 16'h3070, 4'h0, 0, q);
    chk("R6 masked enable", q, 32'h0);
    chk("R6 irq stays low", {31'h0, loc_irq}, 32'h0);
    op(1, 1, 0, 16'h3070, 4'hF, 32'h0080_0000, q);
    chk("R7 loc_irq on", {31'h0, loc_irq}, 32'h1);

    // R5 same-cycle doorbell set and clear of bit 23 on local status
    @(negedge clk);
    host_addr = 32'h081C; host_wr = 1; host_be = 4'hF; host_wdata = 32'h5;
    loc_addr = 32'h3060; loc_wr = 1; loc_be = 4'hF; loc_wdata = 32'h0080_0000;
    @(negedge clk);
    host_wr = 0; loc_wr = 0;
    op(1, 0, 1, 16'h3060, 4'h0, 0, q);
    chk("R5 set wins", q, 32'h0080_0000);
    chk("R5 irq held", {31'h0, loc_irq}, 32'h1);

    // R4 clear with lane 2 disabled has no effect; then a real clear
    op(1, 1, 0, 16'h3060, 4'b1011, 32'hFFFF_FFFF, q);
    op(1, 0, 1, 16'h3060, 4'h0, 0, q);
    chk("R4 lane2 off", q, 32'h0080_0000);
    op(1, 1, 0, 16'h3060, 4'hF, 32'hFFFF_FFFF, q);
    op(1, 0, 1, 16'h3060, 4'h0, 0, q);
    chk("R4 cleared", q, 32'h0);
    chk("R7 loc_irq off", {31'h0, loc_irq}, 32'h0);

    // R3 doorbell set with no byte enable, mailbox untouched
    op(0, 1, 0, 16'h0804, 4'h0, 32'hDEAD_BEEF, q);
    op(1, 0, 1, 16'h3060, 4'h0, 0, q);
    chk("R3 zero-be doorbell", q, 32'h0002_0000);
    op(1, 0, 1, 16'h3B04, 4'h0, 0, q);
    chk("R1 zero-be data", q, 32'h0);

    // R6 reserved status bits read zero after all-ones write
    op(0, 1, 0, 16'h0040, 4'hF, 32'hFFFF_FFFF, q);
    op(0, 0, 1, 16'h0040, 4'h0, 0, q);
    chk("R6 reserved zero", q, 32'h0);
    chk("R7 host_irq off", {31'h0, host_irq}, 32'h0);

    // R8 unmapped write ignored
    op(0, 1, 0, 16'h0C00, 4'hF, 32'hFFFF_FFFF, q);
    op(0, 0, 1, 16'h0C00, 4'h0, 0, q);
    chk("R8 unmapped", q, 32'h0);

    // R10 reset clears storage
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    op(0, 0, 1, 16'h0908, 4'h0, 0, q);
    chk("R10 l2h cleared", q, 32'h0);
    op(1, 0, 1, 16'h3B1C, 4'h0, 0, q);
    chk("R10 h2l cleared", q, 32'h0);
    op(0, 0, 1, 16'h0050, 4'h0, 0, q);
    chk("R10 enable cleared", q, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule